// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Sticky Flags

This block is a 24-bit multiply and multiply-accumulate datapath. Its result is a 48-bit accumulator, which leaves the block as a high half and a low half. A caller pulses `start` with an opcode and two operands. The block offers five operations:

- unsigned multiply
- signed multiply-accumulate
- unsigned multiply-accumulate
- signed fractional multiply with an 8-bit fraction operand
- signed fractional multiply with a 16-bit fraction operand

Two cycles after the start, the result lands in the accumulator, the four condition flags update, and `done` pulses for one cycle.

The accumulate operations are meant for scalar products. Each one can only set its own out-of-range flag: overflow for the signed form, carry for the unsigned form. Neither flag is cleared by an accumulation, so a caller checks it once at the end of a chain. A multiply of either kind clears both flags and starts a fresh sum. The synchronous `clr` input also starts a fresh sum: it zeroes the accumulator and all four flags. In fractional mode, the high half holds the integer part of the product and the low half holds the fraction.

Top module: `mac24_unit`

## Requirements
- R1: Opcode 0 (unsigned multiply) stores the unsigned 48-bit product of `src_a` and `src_b` as {`acc_hi`,`acc_lo`} and clears `flag_c` and `flag_v`.
- R2: Opcode 1 (signed multiply-accumulate) adds the two's-complement product of `src_a` and `src_b` to the accumulator, read as signed. It sets `flag_v` when the exact sum lies outside [-2^47, 2^47-1]. Otherwise `flag_v` keeps its value, and `flag_c` is never altered.
- R3: Opcode 2 (unsigned multiply-accumulate) adds the unsigned product to the accumulator, read as unsigned. It sets `flag_c` when the exact sum exceeds 2^48-1. Otherwise `flag_c` keeps its value, and `flag_v` is never altered.
- R4: Opcodes 3 and 4 (fractional multiply) multiply signed `src_a` by the unsigned fraction `src_b[7:0]`/2^8 (opcode 3) or `src_b[15:0]`/2^16 (opcode 4). The higher bits of `src_b` are ignored. The 48-bit result is the exact product scaled by 2^24: `acc_hi` holds the sign-extended integer part, and `acc_lo` holds the fraction left-aligned with zero low bits. Both opcodes clear `flag_c` and `flag_v`.
- R5: After every operation, `flag_z` is 1 exactly when the 48-bit result is zero, and `flag_n` equals result bit 47.
- R6: Suppose `start` is sampled with a valid opcode at clock edge E. Then the accumulator and flags update at edge E+1, and `done` is high for exactly the one cycle after edge E+1.
- R7: A `start` sampled at the edge directly after an accepted start is ignored. It causes no second `done` and does not affect the result.
- R8: `clr` has priority over any operation. At the next edge it zeroes both halves and all four flags, and it cancels an operation in flight or arriving in the same cycle, so no `done` follows.
- R9: Opcodes 5 to 7 are ignored. No `done` follows, and the accumulator and flags keep their values.
- R10: After reset, both halves, all four flags and `done` are 0.
- R11: Accumulation wraps: the stored result is the exact sum modulo 2^48.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of accumulator and flags |
| start | input | 1 | Begin an operation |
| op_code | input | 3 | Operation select, sampled with start |
| src_a | input | 24 | A operand |
| src_b | input | 24 | B operand |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 24 | Accumulator bits 47:24 |
| acc_lo | output | 24 | Accumulator bits 23:0 |
| flag_c | output | 1 | Sticky unsigned carry |
| flag_v | output | 1 | Sticky signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 47 |

## Verification
The assertions take for granted that `clr`, `start` and `op_code` are driven to known values whenever reset is inactive. They also assume that an operand change while an operation is in flight never matters, because the operands are captured at the accepting edge. The stimulus applies every input at the falling clock edge and holds it through the next rising edge. It drives unknown opcodes, repeated starts and clears that collide with a start on purpose. It never leaves any control input undriven.

// File: rtl/mac24_pkg.sv
package mac24_pkg;

   typedef enum logic [2:0] {
      OP_MULU    = 3'd0,
      OP_MACS    = 3'd1,
      OP_MACU    = 3'd2,
      OP_FRAC_LO = 3'd3,
      OP_FRAC_HI = 3'd4
   } mac_op_e;

   function automatic logic op_known(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

   function automatic logic op_resets_cv(input mac_op_e o);
      return (o == OP_MULU) || (o == OP_FRAC_LO) || (o == OP_FRAC_HI);
   endfunction

endpackage

// File: rtl/mac24_ctrl.sv
module mac24_ctrl
   import mac24_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       start,
   input  logic [2:0] op_code,
   output logic       accept,
   output logic       wr_en,
   output logic       done
);

   logic s1_valid;

   assign accept = start && !s1_valid && !clr && op_known(op_code);
   assign wr_en  = s1_valid && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         done     <= 1'b0;
      end else begin
         s1_valid <= accept;
         done     <= wr_en;
      end
   end

   // R6: completion is a single-cycle pulse
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: a start in the busy cycle never opens a back-to-back stage
   p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> !s1_valid);

   // R9: unknown opcodes are never launched
   p_bad_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !op_known(op_code) && !s1_valid) |=> !s1_valid);

   // R8: clear cancels anything in flight
   p_clr_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!s1_valid && !done));

endmodule

// File: rtl/mac24_prod.sv
module mac24_prod
   import mac24_pkg::*;
#(
   parameter int DW      = 24,
   parameter int FRAC_LO = 8,
   parameter int FRAC_HI = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  mac_op_e         op_in,
   input  logic [DW-1:0]   src_a,
   input  logic [DW-1:0]   src_b,
   output mac_op_e         op_q,
   output logic [2*DW-1:0] term_q
);

   localparam int AW = 2 * DW;

   if (DW < 4) begin : g_bad_dw
      $error("mac24_prod: DW must be at least 4");
   end
   if (FRAC_LO < 1 || FRAC_LO >= FRAC_HI || FRAC_HI > DW - 2) begin : g_bad_frac
      $error("mac24_prod: need 1 <= FRAC_LO < FRAC_HI <= DW-2");
   end

   logic [AW-1:0] uprod;
   logic [AW-1:0] sprod;
   logic [AW-1:0] frac_term [2];
   logic [AW-1:0] term_d;

   assign uprod = {{DW{1'b0}}, src_a} * {{DW{1'b0}}, src_b};
   assign sprod = {{DW{src_a[DW-1]}}, src_a} * {{DW{src_b[DW-1]}}, src_b};

   for (genvar g = 0; g < 2; g++) begin : g_frac
      localparam int FW = (g == 0) ? FRAC_LO : FRAC_HI;
      localparam int PW = DW + FW + 1;
      logic [PW-1:0] fp;
      logic [AW-1:0] fx;
      assign fp = {{(FW+1){src_a[DW-1]}}, src_a} * {{(DW+1){1'b0}}, src_b[FW-1:0]};
      assign fx = {{(AW-PW){fp[PW-1]}}, fp};
      assign frac_term[g] = fx << (DW - FW);
   end

   always_comb begin
      case (op_in)
         OP_MACS:    term_d = sprod;
         OP_FRAC_LO: term_d = frac_term[0];
         OP_FRAC_HI: term_d = frac_term[1];
         default:    term_d = uprod;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_MULU;
         term_q <= '0;
      end else if (load) begin
         op_q   <= op_in;
         term_q <= term_d;
      end
   end

endmodule

// File: rtl/mac24_accum.sv
module mac24_accum
   import mac24_pkg::*;
#(
   parameter int DW = 24
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            wr_en,
   input  mac_op_e         op,
   input  logic [2*DW-1:0] term,
   output logic [2*DW-1:0] acc_q,
   output logic            flag_c,
   output logic            flag_v,
   output logic            flag_z,
   output logic            flag_n
);

   localparam int AW = 2 * DW;

   logic [AW:0]   sum;
   logic [AW-1:0] res;
   logic          c_d;
   logic          v_d;

   always_comb begin
      sum = '0;
      res = term;
      c_d = flag_c;
      v_d = flag_v;
      case (op)
         OP_MACS: begin
            sum = {acc_q[AW-1], acc_q} + {term[AW-1], term};
            res = sum[AW-1:0];
            if (sum[AW] != sum[AW-1]) v_d = 1'b1;
         end
         OP_MACU: begin
            sum = {1'b0, acc_q} + {1'b0, term};
            res = sum[AW-1:0];
            if (sum[AW]) c_d = 1'b1;
         end
         default: begin
            c_d = 1'b0;
            v_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         flag_c <= 1'b0;
         flag_v <= 1'b0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else if (clr) begin
         acc_q  <= '0;
         flag_c <= 1'b0;
         flag_v <= 1'b0;
         flag_z <= 1'b0;
         flag_n <= 1'b0;
      end else if (wr_en) begin
         acc_q  <= res;
         flag_c <= c_d;
         flag_v <= v_d;
         flag_z <= (res == '0);
         flag_n <= res[AW-1];
      end
   end

   // R1 / R4: plain and fractional multiply clear both range flags
   p_mul_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op_resets_cv(op)) |=> (!flag_c && !flag_v));

   // R2: signed accumulate never touches carry; overflow never drops
   p_macs_keep_c_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_MACS) |=> (flag_c == $past(flag_c)));
   p_macs_sticky_v_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_MACS && flag_v) |=> flag_v);

   // R3: unsigned accumulate never touches overflow; carry never drops
   p_macu_keep_v_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_MACU) |=> (flag_v == $past(flag_v)));
   p_macu_sticky_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op == OP_MACU && flag_c) |=> flag_c);

   // R5: zero and sign flags agree with the stored result
   p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (flag_z == (acc_q == '0)));
   p_neg_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (flag_n == acc_q[AW-1]));

   // R8: clear empties the accumulator and flags
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0 && !flag_c && !flag_v && !flag_z && !flag_n));

   // R9: without a write or clear the state holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr) |=> ($stable(acc_q) && $stable(flag_c) && $stable(flag_v)));

endmodule

// File: rtl/mac24_unit.sv
module mac24_unit
   import mac24_pkg::*;
#(
   parameter int DW      = 24,
   parameter int FRAC_LO = 8,
   parameter int FRAC_HI = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start,
   input  logic [2:0]    op_code,
   input  logic [DW-1:0] src_a,
   input  logic [DW-1:0] src_b,
   output logic          done,
   output logic [DW-1:0] acc_hi,
   output logic [DW-1:0] acc_lo,
   output logic          flag_c,
   output logic          flag_v,
   output logic          flag_z,
   output logic          flag_n
);

   localparam int AW = 2 * DW;

   logic          accept;
   logic          wr_en;
   mac_op_e       op_s1;
   logic [AW-1:0] term_s1;
   logic [AW-1:0] acc;

   mac24_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (clr),
      .start   (start),
      .op_code (op_code),
      .accept  (accept),
      .wr_en   (wr_en),
      .done    (done)
   );

   mac24_prod #(
      .DW      (DW),
      .FRAC_LO (FRAC_LO),
      .FRAC_HI (FRAC_HI)
   ) u_prod (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .op_in  (mac_op_e'(op_code)),
      .src_a  (src_a),
      .src_b  (src_b),
      .op_q   (op_s1),
      .term_q (term_s1)
   );

   mac24_accum #(
      .DW (DW)
   ) u_accum (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .wr_en  (wr_en),
      .op     (op_s1),
      .term   (term_s1),
      .acc_q  (acc),
      .flag_c (flag_c),
      .flag_v (flag_v),
      .flag_z (flag_z),
      .flag_n (flag_n)
   );

   assign acc_hi = acc[AW-1:DW];
   assign acc_lo = acc[DW-1:0];

   // R6: an accepted start completes two edges later unless cleared
   p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept ##1 !clr) |=> done);

endmodule

// File: tb/sim_mac24_unit.sv
module sim_mac24_unit;

   typedef struct packed {
      logic [2:0]  op;
      logic [23:0] a;
      logic [23:0] b;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{3'd0, 24'hFFFFFF, 24'hFFFFFF},  // R1 full-range product
      '{3'd2, 24'hFFFFFF, 24'hFFFFFF},  // R3 carry out, R11 wrap
      '{3'd2, 24'h000001, 24'h000001},  // R3 carry stays set
      '{3'd0, 24'h7FFFFF, 24'hFFFFFF},  // R1 clears carry
      '{3'd1, 24'h7FFFFF, 24'h7FFFFF},  // R2 positive overflow
      '{3'd1, 24'h000002, 24'h000003},  // R2 overflow stays set
      '{3'd2, 24'h000001, 24'h000001},  // R3 overflow untouched
      '{3'd0, 24'h000002, 24'h000003},  // R1 small product
      '{3'd1, 24'hFFFFFE, 24'h000003},  // R2 sum to zero, R5
      '{3'd1, 24'hFFFFFF, 24'h000001},  // R5 negative result
      '{3'd1, 24'h800000, 24'h7FFFFF},  // R2 large negative term
      '{3'd3, 24'hFFFFFD, 24'hABCD80},  // R4 8-bit, upper b ignored
      '{3'd4, 24'h000005, 24'hFF4000},  // R4 16-bit
      '{3'd4, 24'h800000, 24'h00FFFF},  // R4 most negative
      '{3'd1, 24'h800000, 24'h7FFFFF},  // R2 negative overflow
      '{3'd3, 24'h000000, 24'h000080}   // R4 zero, R5
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op_code = 3'd0;
   logic [23:0] src_a = '0;
   logic [23:0] src_b = '0;
   logic        done;
   logic [23:0] acc_hi, acc_lo;
   logic        flag_c, flag_v, flag_z, flag_n;

   int n_chk = 0;
   int n_bad = 0;

   logic [47:0] m_acc = '0;
   logic        m_c = 1'b0;
   logic        m_v = 1'b0;

   always #5 clk = ~clk;

   mac24_unit u0 (
      .clk(clk), .rst_n(rst_n), .clr(clr), .start(start), .op_code(op_code),
      .src_a(src_a), .src_b(src_b), .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo),
      .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [2:0] op);
      case (op)
         3'd0:    return "R1";
         3'd1:    return "R2";
         3'd2:    return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic model(input logic [2:0] op, input logic [23:0] a, input logic [23:0] b);
      longint sa, t, bw;
      sa = longint'($signed(a));
      case (op)
         3'd0: begin
            t = longint'({40'd0, a}) * longint'({40'd0, b});
            m_c = 1'b0; m_v = 1'b0;
         end
         3'd1: begin
            t = longint'($signed(m_acc)) + sa * longint'($signed(b));
            if (t < -(64'sd1 <<< 47) || t > ((64'sd1 <<< 47) - 1)) m_v = 1'b1;
         end
         3'd2: begin
            t = longint'({16'd0, m_acc}) + longint'({40'd0, a}) * longint'({40'd0, b});
            if (t > ((64'sd1 <<< 48) - 1)) m_c = 1'b1;
         end
         default: begin
            bw = (op == 3'd3) ? longint'({56'd0, b[7:0]}) : longint'({48'd0, b[15:0]});
            t = sa * bw * ((op == 3'd3) ? 64'sd65536 : 64'sd256);
            m_c = 1'b0; m_v = 1'b0;
         end
      endcase
      m_acc = t[47:0];
   endtask

   task automatic check_state(input string req);
      chk(req, "accumulator", {16'd0, acc_hi, acc_lo}, {16'd0, m_acc});
      chk(req, "carry/overflow", {62'd0, flag_c, flag_v}, {62'd0, m_c, m_v});
      chk("R5", "zero/negative", {62'd0, flag_z, flag_n}, {62'd0, (m_acc == 48'd0), m_acc[47]});
   endtask

   task automatic do_op(input logic [2:0] op, input logic [23:0] a, input logic [23:0] b);
      @(negedge clk);
      start = 1'b1; op_code = op; src_a = a; src_b = b;
      @(negedge clk);
      start = 1'b0;
      chk("R6", "done early", {63'd0, done}, 64'd0);
      @(negedge clk);
      model(op, a, b);
      chk("R6", "done pulse", {63'd0, done}, 64'd1);
      check_state(req_of(op));
      @(negedge clk);
      chk("R6", "done width", {63'd0, done}, 64'd0);
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10", "reset outputs",
          {13'd0, done, acc_hi, acc_lo, flag_c, flag_v, flag_z, flag_n}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) do_op(VEC[i].op, VEC[i].a, VEC[i].b);

      // R7: start held into the busy cycle with a different request
      do_op(3'd0, 24'h000007, 24'h000009);
      @(negedge clk);
      start = 1'b1; op_code = 3'd0; src_a = 24'h000003; src_b = 24'h000004;
      @(negedge clk);
      src_a = 24'h000005; src_b = 24'h000005; op_code = 3'd2;
      @(negedge clk);
      start = 1'b0;
      model(3'd0, 24'h000003, 24'h000004);
      chk("R7", "first done", {63'd0, done}, 64'd1);
      check_state("R7");
      @(negedge clk);
      chk("R7", "no second done", {63'd0, done}, 64'd0);
      @(negedge clk);
      chk("R7", "no second done later", {63'd0, done}, 64'd0);
      check_state("R7");

      // R9: unknown opcode
      for (int k = 5; k < 8; k++) begin
         @(negedge clk);
         start = 1'b1; op_code = 3'(k); src_a = 24'h123456; src_b = 24'h000002;
         @(negedge clk);
         start = 1'b0;
         @(negedge clk);
         chk("R9", "no done", {63'd0, done}, 64'd0);
         check_state("R9");
      end

      // R8: clear while an operation is in flight
      do_op(3'd2, 24'hFFFFFF, 24'hFFFFFF);
      @(negedge clk);
      start = 1'b1; op_code = 3'd0; src_a = 24'h0000FF; src_b = 24'h0000FF;
      @(negedge clk);
      start = 1'b0; clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      m_acc = '0; m_c = 1'b0; m_v = 1'b0;
      chk("R8", "done cancelled", {63'd0, done}, 64'd0);
      chk("R8", "cleared", {16'd0, acc_hi, acc_lo, flag_c, flag_v, flag_z, flag_n}, 64'd0);
      @(negedge clk);
      chk("R8", "done stays low", {63'd0, done}, 64'd0);

      // R8: clear coinciding with start
      @(negedge clk);
      start = 1'b1; clr = 1'b1; op_code = 3'd0; src_a = 24'h000011; src_b = 24'h000011;
      @(negedge clk);
      start = 1'b0; clr = 1'b0;
      @(negedge clk);
      chk("R8", "same-cycle start dropped", {63'd0, done}, 64'd0);
      chk("R8", "still clear", {16'd0, acc_hi, acc_lo, flag_c, flag_v, flag_z, flag_n}, 64'd0);

      // R11: accumulate chain wraps after clear
      do_op(3'd2, 24'hFFFFFF, 24'hFFFFFF);
      do_op(3'd2, 24'hFFFFFF, 24'hFFFFFF);
      do_op(3'd2, 24'hFFFFFF, 24'hFFFFFF);
      chk("R11", "wrapped low bits", {16'd0, acc_hi, acc_lo}, {16'd0, m_acc});

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule